// File: doc/BRIEF.md
# Pulse-Driven Trim Programming Controller

This block turns a serial stream of pre-classified programming pulses into trim-register selection, trim-code stepping and one single-bit fuse-blow command. Two strobes arrive from an upstream pulse classifier. Each is asserted for one clock cycle when a mid-level or high-level pulse has ended. High-level pulses separate the phases of a session. Mid-level pulses are counted in unary: first to pick a register key, then to raise the working code of that register.

A session walks through four phases: idle after power-on, key counting, code counting, and a terminal phase. Every session ends in the terminal phase, and only a power-on reset leaves it. When the blow pulse arrives with a lock-free device and a working code that has exactly one bit set, a one-cycle blow request is issued with that bit as a one-hot index. Otherwise the block raises an error and issues no request. A multi-bit code is therefore burned as several one-bit sessions, in any order.

Top module: `trim_prog_ctrl`

## Requirements
- R1: After reset, state_o is 0 (idle), key_o and code_o are 0, and blow_req_o, pwr_cycle_o and err_o are 0.
- R2: In idle (state 0), a mid strobe changes nothing. A high strobe moves the block to key counting (state 1).
- R3: In key counting, each mid strobe raises key_o by one, saturating at 3.
- R4: A high strobe in key counting with key 1 (sensitivity, 6-bit field) or key 2 (offset, 5-bit field) moves to code counting (state 2). With key 0 or 3, it returns to idle (state 0) and clears key_o to 0.
- R5: In code counting, each mid strobe raises code_o by one. The code saturates at 63 for key 1 and at 31 for key 2.
- R6: code_o never decreases. Only reset brings it back to 0.
- R7: A high strobe in code counting, with lock_in low and code_o having exactly one bit set, has three effects. blow_req_o is high for exactly one cycle. blow_bit_o equals code_o during that cycle. state_o becomes 3 (blown).
- R8: A high strobe in code counting with code_o zero or with two or more bits set issues no blow request. It sets err_o and moves to state 4 (fault).
- R9: While lock_in is high at the blow strobe, no blow request is issued. The block sets err_o and enters state 4.
- R10: In states 3 and 4, pwr_cycle_o is high and all strobes are ignored. state_o, key_o, code_o and err_o stay unchanged until reset.
- R11: When mid and high strobes are both high in one cycle, only the high strobe takes effect. The mid strobe is discarded.
- R12: All outputs are registered. The effect of a strobe sampled at a rising edge is visible right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| mid_pulse | input | 1 | One-cycle strobe: a mid-level pulse ended |
| high_pulse | input | 1 | One-cycle strobe: a high-level pulse ended |
| lock_in | input | 1 | Device lock status; blocks every blow |
| key_o | output | 2 | Selected register key |
| code_o | output | 6 | Working trim code |
| blow_req_o | output | 1 | One-cycle fuse blow request |
| blow_bit_o | output | 6 | One-hot index of the bit to blow |
| pwr_cycle_o | output | 1 | Session finished; power cycle required |
| err_o | output | 1 | Blow refused (bad code or lock) |
| state_o | output | 3 | Phase: 0 idle, 1 key, 2 code, 3 blown, 4 fault |

## Verification
A counting step (mid strobe) and a phase change (high strobe) can land on the same clock edge. The bench drives both strobes on one edge in idle, in key counting and in code counting. In idle, the check is that key_o stays 0 while the phase advances. In key counting, the key must not move while code counting is entered. In code counting, the code must hold at the one-hot value 2, so the blow bit is 2 and not the two-bit value 3 that would force a fault.

// File: rtl/trim_prog_pkg.sv
package trim_prog_pkg;

  typedef enum logic [2:0] {
    ST_INIT  = 3'd0,
    ST_SEL   = 3'd1,
    ST_ADDR  = 3'd2,
    ST_BLOWN = 3'd3,
    ST_FAULT = 3'd4
  } trim_state_e;

  localparam int unsigned KEY_SENS = 1;
  localparam int unsigned KEY_OFS  = 2;

  // largest code of a w-bit field
  function automatic int unsigned field_max(int unsigned w);
    return (32'd1 << w) - 32'd1;
  endfunction

  // increment that stops at lim
  function automatic int unsigned sat_inc(int unsigned v, int unsigned lim);
    return (v >= lim) ? lim : v + 32'd1;
  endfunction

  // a code can be burned only if exactly one bit is set
  function automatic logic code_is_blowable(int unsigned v);
    return (v != 0) && ((v & (v - 32'd1)) == 0);
  endfunction

endpackage

// File: rtl/trim_evt_arb.sv
module trim_evt_arb (
  input  logic clk,
  input  logic rst_n,
  input  logic mid_pulse,
  input  logic high_pulse,
  output logic mid_ok,
  output logic high_ok
);

  // a high strobe wins; a coincident mid strobe is dropped
  assign high_ok = high_pulse;
  assign mid_ok  = mid_pulse & ~high_pulse;

  // R11
  evt_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mid_ok && high_ok));

  // R11
  evt_mid_dropped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mid_pulse && high_pulse) |-> !mid_ok);

endmodule

// File: rtl/trim_code_ctr.sv
module trim_code_ctr
  import trim_prog_pkg::*;
#(
  parameter int KEY_W  = 2,
  parameter int CODE_W = 6,
  parameter int SENS_W = 6,
  parameter int OFS_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              key_inc,
  input  logic              key_clr,
  input  logic              code_inc,
  output logic [KEY_W-1:0]  key_q,
  output logic [CODE_W-1:0] code_q
);

  localparam int unsigned KEY_LIM = field_max(KEY_W);

  logic [CODE_W-1:0] code_lim;

  always_comb begin
    if (32'(key_q) == KEY_SENS)     code_lim = CODE_W'(field_max(SENS_W));
    else if (32'(key_q) == KEY_OFS) code_lim = CODE_W'(field_max(OFS_W));
    else                            code_lim = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      key_q  <= '0;
      code_q <= '0;
    end else begin
      if (key_clr)      key_q <= '0;
      else if (key_inc) key_q <= KEY_W'(sat_inc(32'(key_q), KEY_LIM));
      if (code_inc)     code_q <= CODE_W'(sat_inc(32'(code_q), 32'(code_lim)));
    end
  end

  // R6
  code_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> code_q >= $past(code_q));

  // R5
  code_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (code_inc && code_q == code_lim) |=> code_q == $past(code_q));

  // R3
  key_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (key_inc && !key_clr && 32'(key_q) == KEY_LIM) |=> 32'(key_q) == KEY_LIM);

endmodule

// File: rtl/trim_seq_fsm.sv
module trim_seq_fsm
  import trim_prog_pkg::*;
#(
  parameter int KEY_W  = 2,
  parameter int CODE_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mid_ok,
  input  logic              high_ok,
  input  logic              locked,
  input  logic [KEY_W-1:0]  key_q,
  input  logic [CODE_W-1:0] code_q,
  output logic              key_inc,
  output logic              key_clr,
  output logic              code_inc,
  output trim_state_e       state_q,
  output logic              blow_req,
  output logic [CODE_W-1:0] blow_bit,
  output logic              err,
  output logic              pwr_cycle
);

  trim_state_e state_d;
  logic        key_valid;
  logic        blow_ok;
  logic        blow_bad;

  assign key_valid = (32'(key_q) == KEY_SENS) || (32'(key_q) == KEY_OFS);
  assign key_inc   = (state_q == ST_SEL)  && mid_ok;
  assign key_clr   = (state_q == ST_SEL)  && high_ok && !key_valid;
  assign code_inc  = (state_q == ST_ADDR) && mid_ok;
  assign blow_ok   = (state_q == ST_ADDR) && high_ok && !locked
                     && code_is_blowable(32'(code_q));
  assign blow_bad  = (state_q == ST_ADDR) && high_ok && !blow_ok;
  assign pwr_cycle = (state_q == ST_BLOWN) || (state_q == ST_FAULT);

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_INIT: if (high_ok) state_d = ST_SEL;
      ST_SEL:  if (high_ok) state_d = key_valid ? ST_ADDR : ST_INIT;
      ST_ADDR: if (high_ok) state_d = blow_ok ? ST_BLOWN : ST_FAULT;
      default: state_d = state_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_INIT;
      blow_req <= 1'b0;
      blow_bit <= '0;
      err      <= 1'b0;
    end else begin
      state_q  <= state_d;
      blow_req <= blow_ok;
      blow_bit <= blow_ok ? code_q : '0;
      if (blow_bad) err <= 1'b1;
    end
  end

  // R9
  lock_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    blow_req |-> !$past(locked));

  // R7
  blow_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    blow_req |-> $countones(blow_bit) == 1);

  // R7
  single_blow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    blow_req |=> !blow_req);

  // R10
  halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_cycle |=> pwr_cycle && $stable(state_q) && $stable(err));

  // R8
  fault_no_blow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> !blow_req && state_q == ST_FAULT);

endmodule

// File: rtl/trim_prog_ctrl.sv
module trim_prog_ctrl
  import trim_prog_pkg::*;
#(
  parameter int KEY_W  = 2,
  parameter int SENS_W = 6,
  parameter int OFS_W  = 5,
  parameter int CODE_W = (SENS_W > OFS_W) ? SENS_W : OFS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mid_pulse,
  input  logic              high_pulse,
  input  logic              lock_in,
  output logic [KEY_W-1:0]  key_o,
  output logic [CODE_W-1:0] code_o,
  output logic              blow_req_o,
  output logic [CODE_W-1:0] blow_bit_o,
  output logic              pwr_cycle_o,
  output logic              err_o,
  output logic [2:0]        state_o
);

  logic        mid_ok, high_ok;
  logic        key_inc, key_clr, code_inc;
  trim_state_e state_q;

  trim_evt_arb u_arb (
    .clk        (clk),
    .rst_n      (rst_n),
    .mid_pulse  (mid_pulse),
    .high_pulse (high_pulse),
    .mid_ok     (mid_ok),
    .high_ok    (high_ok)
  );

  trim_code_ctr #(
    .KEY_W (KEY_W), .CODE_W (CODE_W), .SENS_W (SENS_W), .OFS_W (OFS_W)
  ) u_ctr (
    .clk      (clk),
    .rst_n    (rst_n),
    .key_inc  (key_inc),
    .key_clr  (key_clr),
    .code_inc (code_inc),
    .key_q    (key_o),
    .code_q   (code_o)
  );

  trim_seq_fsm #(
    .KEY_W (KEY_W), .CODE_W (CODE_W)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .mid_ok    (mid_ok),
    .high_ok   (high_ok),
    .locked    (lock_in),
    .key_q     (key_o),
    .code_q    (code_o),
    .key_inc   (key_inc),
    .key_clr   (key_clr),
    .code_inc  (code_inc),
    .state_q   (state_q),
    .blow_req  (blow_req_o),
    .blow_bit  (blow_bit_o),
    .err       (err_o),
    .pwr_cycle (pwr_cycle_o)
  );

  assign state_o = state_q;

  // R10
  frozen_when_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_cycle_o |=> $stable(code_o) && $stable(key_o));

endmodule

// File: tb/test_trim_prog_ctrl.sv
`timescale 1ns/1ps
module test_trim_prog_ctrl;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mid_pulse = 1'b0, high_pulse = 1'b0, lock_in = 1'b0;
  logic [1:0] key_o;
  logic [5:0] code_o, blow_bit_o;
  logic       blow_req_o, pwr_cycle_o, err_o;
  logic [2:0] state_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  trim_prog_ctrl i_trim_prog_ctrl (
    .clk (clk), .rst_n (rst_n), .mid_pulse (mid_pulse), .high_pulse (high_pulse),
    .lock_in (lock_in), .key_o (key_o), .code_o (code_o), .blow_req_o (blow_req_o),
    .blow_bit_o (blow_bit_o), .pwr_cycle_o (pwr_cycle_o), .err_o (err_o),
    .state_o (state_o)
  );

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; mid_pulse = 1'b0; high_pulse = 1'b0; lock_in = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // one strobe cycle; results are sampled at the following falling edge
  task automatic strobe(bit m, bit h);
    mid_pulse = m; high_pulse = h;
    @(negedge clk);
    mid_pulse = 1'b0; high_pulse = 1'b0;
  endtask

  task automatic mids(int n);
    for (int i = 0; i < n; i++) strobe(1'b1, 1'b0);
  endtask

  task automatic enter_addr(int key);
    do_reset();
    strobe(1'b0, 1'b1);
    mids(key);
    strobe(1'b0, 1'b1);
  endtask

  task automatic t_reset();
    do_reset();
    check("R1", "state", int'(state_o), 0);
    check("R1", "key", int'(key_o), 0);
    check("R1", "code", int'(code_o), 0);
    check("R1", "blow_req", int'(blow_req_o), 0);
    check("R1", "pwr_cycle", int'(pwr_cycle_o), 0);
    check("R1", "err", int'(err_o), 0);
  endtask

  task automatic t_init_ignore();
    do_reset();
    mids(3);
    check("R2", "state after mids", int'(state_o), 0);
    check("R2", "key after mids", int'(key_o), 0);
    strobe(1'b0, 1'b1);
    check("R2", "state after high", int'(state_o), 1);
  endtask

  task automatic t_key_count();
    do_reset();
    strobe(1'b0, 1'b1);
    strobe(1'b1, 1'b0);
    check("R12", "key right after first mid", int'(key_o), 1);
    mids(4);
    check("R3", "key saturates", int'(key_o), 3);
    strobe(1'b0, 1'b1);
    check("R4", "key 3 aborts state", int'(state_o), 0);
    check("R4", "key 3 abort clears key", int'(key_o), 0);
    strobe(1'b0, 1'b1);
    strobe(1'b0, 1'b1);
    check("R4", "key 0 aborts state", int'(state_o), 0);
  endtask

  task automatic t_sens_sat();
    enter_addr(1);
    check("R4", "key 1 enters addressing", int'(state_o), 2);
    mids(70);
    check("R5", "sens code saturates", int'(code_o), 63);
    strobe(1'b0, 1'b1);
    check("R8", "multi-bit blow faults", int'(state_o), 4);
    check("R8", "multi-bit blow err", int'(err_o), 1);
    check("R8", "multi-bit no blow", int'(blow_req_o), 0);
    check("R10", "pwr_cycle in fault", int'(pwr_cycle_o), 1);
    strobe(1'b0, 1'b1);
    mids(2);
    check("R10", "fault state frozen", int'(state_o), 4);
    check("R10", "fault code frozen", int'(code_o), 63);
    do_reset();
    check("R6", "reset clears code", int'(code_o), 0);
  endtask

  task automatic t_ofs_blow();
    enter_addr(2);
    check("R4", "key 2 enters addressing", int'(state_o), 2);
    mids(40);
    check("R5", "offset code saturates", int'(code_o), 31);
    enter_addr(2);
    mids(4);
    check("R5", "code counts", int'(code_o), 4);
    strobe(1'b0, 1'b1);
    check("R7", "blow_req", int'(blow_req_o), 1);
    check("R7", "blow_bit", int'(blow_bit_o), 4);
    check("R7", "state blown", int'(state_o), 3);
    check("R7", "no err", int'(err_o), 0);
    strobe(1'b1, 1'b0);
    check("R7", "blow_req one cycle", int'(blow_req_o), 0);
    check("R10", "code frozen after blow", int'(code_o), 4);
    strobe(1'b0, 1'b1);
    check("R10", "no second blow", int'(blow_req_o), 0);
    check("R10", "pwr_cycle after blow", int'(pwr_cycle_o), 1);
  endtask

  task automatic t_zero_and_lock();
    enter_addr(1);
    strobe(1'b0, 1'b1);
    check("R8", "zero code faults", int'(state_o), 4);
    check("R8", "zero code err", int'(err_o), 1);
    enter_addr(1);
    mids(1);
    lock_in = 1'b1;
    strobe(1'b0, 1'b1);
    check("R9", "locked no blow", int'(blow_req_o), 0);
    check("R9", "locked faults", int'(state_o), 4);
    check("R9", "locked err", int'(err_o), 1);
    lock_in = 1'b0;
  endtask

  task automatic t_same_cycle();
    do_reset();
    strobe(1'b1, 1'b1);
    check("R11", "both in idle: state", int'(state_o), 1);
    check("R11", "both in idle: key", int'(key_o), 0);
    strobe(1'b1, 1'b0);
    strobe(1'b1, 1'b1);
    check("R11", "both in select: state", int'(state_o), 2);
    check("R11", "both in select: key", int'(key_o), 1);
    mids(2);
    strobe(1'b1, 1'b1);
    check("R11", "both in addressing: blow", int'(blow_req_o), 1);
    check("R11", "both in addressing: bit", int'(blow_bit_o), 2);
  endtask

  initial begin
    t_reset();
    t_init_ignore();
    t_key_count();
    t_sens_sat();
    t_ofs_blow();
    t_zero_and_lock();
    t_same_cycle();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL R12 watchdog: actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule